// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is the transmit side of a half-duplex synchronous serial link on which it is the bus master. It drives a serial clock line and a data line. A word written on the parallel port lands in a one-entry holding buffer. From there it moves into a shift register as soon as the shift register is free, and the bits leave least significant first. While one word is shifting, the next can wait in the buffer, so a stream of words goes out with no idle clock periods between them.

The serial clock period is four times the divider value plus one, counted in system clocks. The line rests at a selectable idle level between words. The data line changes on the clock edge that leaves the idle level, and the receiver samples on the edge that returns to it. Words are 8 bits, or 9 bits when the extended-word control is set at the moment of transfer. A buffer-empty flag, gated by an interrupt enable, tells the producer when to write again. A separate status bit reports an empty shift register and has to be polled. The receive path is assumed to be held off by its owner while this block transmits.

Top module: `stx_master_tx`

## Requirements
- R1: After reset, sck_out equals clk_pol, sdo_out is 0, buf_empty is 1 and tsr_empty is 1.
- R2: Whenever no word is shifting, sck_out sits at the idle level, which is the value of clk_pol (1 gives a high idle, 0 a low idle).
- R3: Each bit lasts 4*(baud_div+1) system clocks. The first 2*(baud_div+1) clocks are at the active level (not clk_pol) and the rest are at the idle level.
- R4: With tx_en high, a full buffer and an empty shift register, the word transfers on the next clock edge. After that edge buf_empty is 1 (unless the same cycle wrote new data), tsr_empty is 0 and the first bit is driven.
- R5: buf_empty goes to 0 only in response to a write and goes to 1 only on a transfer. The int_en setting has no effect on it.
- R6: tsr_empty is 1 exactly when no word is in the shift register.
- R7: Bits leave in the order bit 0 to bit 7. sdo_out changes only on the clock edge that leaves the idle level, and it is 0 while no word shifts.
- R8: If ninth_en is 1 at the transfer, the word is 9 bits long and the value of wr_bit9 captured with the write is sent last, as bit 8.
- R9: If the buffer is full when the last bit period of a word ends, the next word's first bit starts on the very next clock. No idle period is inserted.
- R10: While tx_en is 0, any word in progress is dropped, sck_out returns to idle and tsr_empty is 1. The buffer keeps its content, and that content is sent once tx_en returns to 1.
- R11: irq is 1 exactly when buf_empty and int_en are both 1.
- R12: A write while the buffer is still full replaces the waiting word. Only the latest word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and holds the shifter idle |
| ninth_en | input | 1 | Selects 9-bit words, sampled at transfer |
| clk_pol | input | 1 | Idle level of the serial clock |
| int_en | input | 1 | Interrupt enable for the buffer-empty flag |
| baud_div | input | DIV_W | Divider; the bit period is 4*(baud_div+1) clocks |
| wr_valid | input | 1 | One-cycle write strobe into the holding buffer |
| wr_data | input | 8 | Data byte to send |
| wr_bit9 | input | 1 | Ninth bit written along with wr_data |
| sck_out | output | 1 | Serial clock line |
| sdo_out | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer empty flag |
| tsr_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Buffer-empty interrupt request |

## Verification
The bench aims at the word boundary. A second word written during the first must start on the clock right after the first word's last idle half. A design that re-armed through the idle state would insert one dead cycle there, and the cycle-by-cycle comparison catches it. Aborting mid-word while a write arrives with the transmitter disabled checks two things at once: that the shifter drops its word, and that the buffered byte survives and goes out after re-enable. A design that flushed the buffer would never show that byte on the data line. The bench also runs 9-bit words, overwrites of a full buffer, a high idle polarity with a non-zero divider, and a masked interrupt. A wrong bit count, a stale byte, a mis-sized half period or an irq that ignores its enable each turns up as a mismatch on the first affected cycle.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef struct packed {
    logic       b9;
    logic [7:0] d;
  } stx_word_t;

  // clocks spent at one level of the serial clock
  function automatic int unsigned stx_half_len(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // index of the final bit in a word
  function automatic logic [3:0] stx_last_idx(input logic ext);
    return ext ? 4'd8 : 4'd7;
  endfunction

endpackage

// File: rtl/stx_phase_timer.sv
module stx_phase_timer
  import stx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             half_end
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_c;

  assign last_c   = CNT_W'(stx_half_len(32'(div)) - 1);
  assign half_end = run && (cnt == last_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || half_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/stx_hold_buf.sv
module stx_hold_buf
  import stx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_valid,
  input  stx_word_t wr_word,
  input  logic      take,
  output logic      full,
  output stx_word_t word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (wr_valid) begin
        full <= 1'b1;
        word <= wr_word;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  input  logic      ninth_en,
  input  logic      hold_full,
  input  stx_word_t hold_word,
  input  logic      half_end,
  output logic      busy,
  output logic      sck_act,
  output logic      sdo,
  output logic      xfer
);
  logic [8:0] sr;
  logic [3:0] bit_idx;
  logic [3:0] last_idx;
  logic       bit_end;
  logic       word_end;

  assign bit_end  = busy && !sck_act && half_end;
  assign word_end = bit_end && (bit_idx == last_idx);
  assign xfer     = tx_en && hold_full && (!busy || word_end);
  assign sdo      = busy & sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck_act  <= 1'b0;
      sr       <= '0;
      bit_idx  <= '0;
      last_idx <= 4'd7;
    end else if (!tx_en) begin
      busy    <= 1'b0;
      sck_act <= 1'b0;
    end else if (xfer) begin
      busy     <= 1'b1;
      sck_act  <= 1'b1;
      sr       <= hold_word;
      bit_idx  <= '0;
      last_idx <= stx_last_idx(ninth_en);
    end else if (word_end) begin
      busy    <= 1'b0;
      sck_act <= 1'b0;
    end else if (busy && half_end) begin
      sck_act <= ~sck_act;
      if (bit_end) begin
        sr      <= {1'b0, sr[8:1]};
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stx_master_tx.sv
module stx_master_tx
  import stx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             ninth_en,
  input  logic             clk_pol,
  input  logic             int_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             wr_bit9,
  output logic             sck_out,
  output logic             sdo_out,
  output logic             buf_empty,
  output logic             tsr_empty,
  output logic             irq
);
  stx_word_t wr_word;
  stx_word_t hold_word;
  logic      hold_full;
  logic      xfer_evt;
  logic      half_end;
  logic      busy;
  logic      sck_act;

  assign wr_word = '{b9: wr_bit9, d: wr_data};

  stx_hold_buf u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_word  (wr_word),
    .take     (xfer_evt),
    .full     (hold_full),
    .word     (hold_word)
  );

  stx_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .restart  (xfer_evt),
    .div      (baud_div),
    .half_end (half_end)
  );

  stx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .ninth_en  (ninth_en),
    .hold_full (hold_full),
    .hold_word (hold_word),
    .half_end  (half_end),
    .busy      (busy),
    .sck_act   (sck_act),
    .sdo       (sdo_out),
    .xfer      (xfer_evt)
  );

  assign sck_out   = clk_pol ^ sck_act;
  assign buf_empty = ~hold_full;
  assign tsr_empty = ~busy;
  assign irq       = buf_empty & int_en;

endmodule

// File: rtl/stx_sva.sv
module stx_sva (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic int_en,
  input logic clk_pol,
  input logic wr_valid,
  input logic xfer_evt,
  input logic sck_out,
  input logic sdo_out,
  input logic buf_empty,
  input logic tsr_empty,
  input logic irq
);

  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && !wr_valid) |=> (buf_empty && !tsr_empty)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && !wr_valid) |=> buf_empty); // R5

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !buf_empty); // R12

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> (sck_out == clk_pol)); // R2

  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tsr_empty); // R10

  AST_DATA_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsr_empty && $past(!tsr_empty) && !$stable(sdo_out)) |-> (sck_out != clk_pol)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq); // R11

endmodule

bind stx_master_tx stx_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .int_en    (int_en),
  .clk_pol   (clk_pol),
  .wr_valid  (wr_valid),
  .xfer_evt  (xfer_evt),
  .sck_out   (sck_out),
  .sdo_out   (sdo_out),
  .buf_empty (buf_empty),
  .tsr_empty (tsr_empty),
  .irq       (irq)
);

// File: tb/stx_master_tx_test.sv
`timescale 1ns/1ps
module stx_master_tx_test;
  localparam int DIV_W = 8;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, ninth_en = 1'b0, clk_pol = 1'b0, int_en = 1'b0;
  logic [DIV_W-1:0] baud_div = '0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_bit9 = 1'b0;
  logic sck_out, sdo_out, buf_empty, tsr_empty, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string phase = "R1 reset";

  // behavioural reference state
  bit [8:0] mq[$];
  bit [8:0] m_word = '0;
  int m_n = 8;
  int m_pos = 0;
  bit m_busy = 0;

  always #2.5 clk = ~clk;

  stx_master_tx #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ninth_en(ninth_en),
    .clk_pol(clk_pol), .int_en(int_en), .baud_div(baud_div),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .sck_out(sck_out), .sdo_out(sdo_out), .buf_empty(buf_empty),
    .tsr_empty(tsr_empty), .irq(irq)
  );

  task automatic check(input string req, input string sig, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%b expected=%b at %0t", req, phase, sig, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit start;
    int h;
    bit e_act;
    start = 0;
    if (!rst_n) begin
      mq.delete();
      m_busy = 0; m_pos = 0; m_word = '0; m_n = 8;
    end else begin
      if (!tx_en) begin
        m_busy = 0; m_pos = 0;
      end else if (m_busy) begin
        m_pos++;
        if (m_pos == m_n * 4 * (int'(baud_div) + 1)) begin
          if (mq.size() > 0) start = 1;
          else begin m_busy = 0; m_pos = 0; end
        end
      end else if (mq.size() > 0) begin
        start = 1;
      end
      if (start) begin
        m_word = mq.pop_front();
        m_n = ninth_en ? 9 : 8;
        m_pos = 0;
        m_busy = 1;
      end
      if (wr_valid) begin
        mq.delete();
        mq.push_back({wr_bit9, wr_data});
      end
    end
    #1;
    if (rst_n) begin
      h = 2 * (int'(baud_div) + 1);
      e_act = m_busy && (((m_pos / h) % 2) == 0);
      check("R3", "sck_out", sck_out, clk_pol ^ e_act);
      check("R7", "sdo_out", sdo_out, m_busy ? m_word[m_pos / (2 * h)] : 1'b0);
      check("R5", "buf_empty", buf_empty, mq.size() == 0);
      check("R6", "tsr_empty", tsr_empty, !m_busy);
      check("R11", "irq", irq, (mq.size() == 0) && int_en);
    end
  end

  task automatic put(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "sck_out", sck_out, clk_pol);
    check("R1", "sdo_out", sdo_out, 1'b0);
    check("R1", "buf_empty", buf_empty, 1'b1);
    check("R1", "tsr_empty", tsr_empty, 1'b1);
    @(negedge clk);
    tx_en = 1'b1; int_en = 1'b1;

    phase = "R4 R7 single word";
    put(8'hA5, 1'b0);
    idle(40);

    phase = "R9 back to back";
    put(8'h3C, 1'b0);
    put(8'h81, 1'b0);
    idle(80);

    phase = "R2 R3 high idle, divider 2";
    clk_pol = 1'b1; baud_div = 8'd2;
    idle(2);
    put(8'h5A, 1'b0);
    idle(110);

    phase = "R8 ninth bit";
    ninth_en = 1'b1; baud_div = 8'd1;
    idle(2);
    put(8'h0F, 1'b1);
    put(8'hF0, 1'b0);
    idle(160);
    ninth_en = 1'b0;

    phase = "R10 abort and resume";
    clk_pol = 1'b0; baud_div = 8'd0;
    idle(2);
    put(8'hFF, 1'b0);
    idle(9);
    tx_en = 1'b0;
    put(8'h12, 1'b0);
    idle(6);
    tx_en = 1'b1;
    idle(50);

    phase = "R11 R5 masked interrupt";
    int_en = 1'b0;
    idle(3);
    put(8'h96, 1'b0);
    idle(40);
    int_en = 1'b1;

    phase = "R12 overwrite while full";
    put(8'hC3, 1'b0);
    put(8'h11, 1'b0);
    put(8'h22, 1'b0);
    idle(90);

    phase = "R3 divider 5";
    baud_div = 8'd5;
    idle(2);
    put(8'h6B, 1'b0);
    idle(200);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule